// File: doc/BRIEF.md
# SPI FIFO Interrupt and Status Unit

This unit sits beside the shift engine and FIFOs of an SPI controller and turns their state into one interrupt request. The datapath supplies the current fill level of the transmit and receive FIFOs, plus single-cycle pulses for three error events: receive overrun, mode fault and transmit underflow. The unit compares the levels against two programmable thresholds and produces four level-driven flags. It latches the three events as sticky flags. All seven flags appear in one status word.

Software chooses which flags may raise the interrupt. Writing ones to a set port adds sources to the interrupt mask. Writing ones to a clear port removes them. The mask itself can only be read. Sticky flags are cleared by writing one to their status bit, so writing back the word just read acknowledges every pending event. The level flags always follow the FIFOs and cannot be written. The interrupt output is a register: the OR of the enabled, active flags.

The register port is a simple word interface. A write takes effect at the next clock edge. A read returns registered data one cycle after the request, with a valid strobe.

Top module: `spi_irq_unit`

## Requirements
- R1: After reset, the mask is 0, the interrupt output is 0, both thresholds are 1, the sticky flags are 0, and the read-valid strobe is 0.
- R2: A write to the mask-set port (address 1) sets every mask bit whose data bit is one and leaves the other mask bits unchanged. Reads of address 1 and address 2 return 0.
- R3: A write to the mask-clear port (address 2) clears every mask bit whose data bit is one and leaves the other mask bits unchanged.
- R4: The mask is read at address 3. A write to address 3 has no effect on it.
- R5: Status bit 2 (transmit low) is 1 exactly when the transmit level is below the transmit threshold (address 4). With a threshold of 1, it means the transmit FIFO is empty.
- R6: Status bit 3 (transmit full) is 1 exactly when the transmit level equals the FIFO depth.
- R7: Status bit 4 (receive available) is 1 exactly when the receive level is at or above the receive threshold (address 5). With a threshold of 1, it means any data is present.
- R8: Status bit 5 (receive full) is 1 exactly when the receive level equals the FIFO depth.
- R9: Status bits 0 (receive overrun), 1 (mode fault) and 6 (transmit underflow) are set by a one-cycle pulse on their event input. They stay set until they are cleared.
- R10: A write to the status word (address 0) clears each sticky bit whose data bit is one. The level bits 2 to 5 do not change, and writing back the value just read clears every pending sticky bit.
- R11: If an event pulse and a clearing write for the same bit fall in the same cycle, the bit stays set.
- R12: The interrupt output is the OR over all bits of status AND mask, registered, so it follows a change in status one clock later.
- R13: The two threshold registers are written and read back independently. A write to one leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 3 | Register address: 0 status, 1 mask set, 2 mask clear, 3 mask, 4 transmit threshold, 5 receive threshold |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, valid one cycle after rdEn |
| rdValid | output | 1 | High in the cycle after a read request |
| txLevel | input | LEVEL_W | Transmit FIFO fill level |
| rxLevel | input | LEVEL_W | Receive FIFO fill level |
| evRxOverrun | input | 1 | Receive overrun event pulse |
| evModeFail | input | 1 | Mode fault event pulse |
| evTxUnderflow | input | 1 | Transmit underflow event pulse |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench sets the FIFO levels one below, exactly at and above each threshold, and at full depth. A comparator off by one would set the transmit-low or receive-available flag one entry too early or too late. It issues a clearing write in the same cycle as an event pulse: a design that gives the write priority would lose that event. It writes ones to the level bits and to the read-only mask address: a design that lets these writes through would clear a level flag or corrupt the enabled set. It checks the interrupt both before and after the clock edge that follows a level change. This catches an output that is combinational, or that lags by more than one register.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int NUM_SRC = 7;
  localparam int ADDR_W  = 3;

  localparam int BIT_RX_OVR   = 0;
  localparam int BIT_MODE_ERR = 1;
  localparam int BIT_TX_LOW   = 2;
  localparam int BIT_TX_FULL  = 3;
  localparam int BIT_RX_AVAIL = 4;
  localparam int BIT_RX_FULL  = 5;
  localparam int BIT_TX_UNDER = 6;

  // Bits that latch an event rather than follow a level.
  localparam logic [NUM_SRC-1:0] STICKY_SET = 7'b100_0011;

  typedef enum logic [ADDR_W-1:0] {
    RS_STATUS  = 3'd0,
    RS_MASKSET = 3'd1,
    RS_MASKCLR = 3'd2,
    RS_MASK    = 3'd3,
    RS_TXTHR   = 3'd4,
    RS_RXTHR   = 3'd5
  } regSel_e;

  typedef struct packed {
    logic wrStatus;
    logic wrMaskSet;
    logic wrMaskClr;
    logic wrTxThr;
    logic wrRxThr;
  } ctrlStrobes_t;
endpackage

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LEVEL_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_SRC-1:0]   statusVal,
  input  logic [NUM_SRC-1:0]   maskVal,
  input  logic [LEVEL_W-1:0]   txThr,
  input  logic [LEVEL_W-1:0]   rxThr,
  output ctrlStrobes_t         strobes,
  output logic [DATA_W-1:0]    rdData,
  output logic                 rdValid
);
  regSel_e sel;
  logic [DATA_W-1:0] rdNext;

  assign sel = regSel_e'(addr);

  always_comb begin
    strobes = '0;
    if (wrEn) begin
      unique case (sel)
        RS_STATUS:  strobes.wrStatus  = 1'b1;
        RS_MASKSET: strobes.wrMaskSet = 1'b1;
        RS_MASKCLR: strobes.wrMaskClr = 1'b1;
        RS_TXTHR:   strobes.wrTxThr   = 1'b1;
        RS_RXTHR:   strobes.wrRxThr   = 1'b1;
        default:    strobes = '0;
      endcase
    end
  end

  always_comb begin
    rdNext = '0;
    unique case (sel)
      RS_STATUS: rdNext = DATA_W'(statusVal);
      RS_MASK:   rdNext = DATA_W'(maskVal);
      RS_TXTHR:  rdNext = DATA_W'(txThr);
      RS_RXTHR:  rdNext = DATA_W'(rxThr);
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) rdData <= rdNext;
    end
  end

  a_r2_setclr_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (addr == RS_MASKSET || addr == RS_MASKCLR)) |=> (rdData == '0));

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));
endmodule

// File: rtl/spi_irq_datapath.sv
module spi_irq_datapath
  import spi_irq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int DEPTH      = 128,
  parameter int LEVEL_W    = 8,
  parameter int TX_THR_RST = 1,
  parameter int RX_THR_RST = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [LEVEL_W-1:0] txLevel,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic               evRxOverrun,
  input  logic               evModeFail,
  input  logic               evTxUnderflow,
  output logic [NUM_SRC-1:0] statusVal,
  output logic [NUM_SRC-1:0] maskVal,
  output logic [LEVEL_W-1:0] txThr,
  output logic [LEVEL_W-1:0] rxThr,
  output logic               irq
);
  localparam logic [LEVEL_W-1:0] FULL_LVL = LEVEL_W'(DEPTH);

  logic [NUM_SRC-1:0] eventVec;
  logic [NUM_SRC-1:0] levelVec;
  logic [NUM_SRC-1:0] wrBits;
  logic [NUM_SRC-1:0] maskQ;
  logic [LEVEL_W-1:0] txThrQ;
  logic [LEVEL_W-1:0] rxThrQ;
  logic               irqQ;
  logic               unusedBits;

  assign wrBits     = wrData[NUM_SRC-1:0];
  assign unusedBits = ^{wrData, eventVec, levelVec};

  always_comb begin
    eventVec               = '0;
    eventVec[BIT_RX_OVR]   = evRxOverrun;
    eventVec[BIT_MODE_ERR] = evModeFail;
    eventVec[BIT_TX_UNDER] = evTxUnderflow;
  end

  always_comb begin
    levelVec               = '0;
    levelVec[BIT_TX_LOW]   = (txLevel < txThrQ);
    levelVec[BIT_TX_FULL]  = (txLevel == FULL_LVL);
    levelVec[BIT_RX_AVAIL] = (rxLevel >= rxThrQ);
    levelVec[BIT_RX_FULL]  = (rxLevel == FULL_LVL);
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (STICKY_SET[i]) begin : g_sticky
      logic stickyQ;
      always_ff @(posedge clk) begin
        if (!rstN) stickyQ <= 1'b0;
        else if (eventVec[i]) stickyQ <= 1'b1;
        else if (strobes.wrStatus && wrBits[i]) stickyQ <= 1'b0;
      end
      assign statusVal[i] = stickyQ;

      a_r11_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
        (eventVec[i] || (statusVal[i] && !(strobes.wrStatus && wrBits[i])))
          |=> statusVal[i]);
      a_r10_sticky_clear: assert property (@(posedge clk) disable iff (!rstN)
        (strobes.wrStatus && wrBits[i] && !eventVec[i]) |=> !statusVal[i]);
    end else begin : g_level
      assign statusVal[i] = levelVec[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) maskQ <= '0;
    else if (strobes.wrMaskSet) maskQ <= maskQ | wrBits;
    else if (strobes.wrMaskClr) maskQ <= maskQ & ~wrBits;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txThrQ <= LEVEL_W'(TX_THR_RST);
      rxThrQ <= LEVEL_W'(RX_THR_RST);
    end else begin
      if (strobes.wrTxThr) txThrQ <= wrData[LEVEL_W-1:0];
      if (strobes.wrRxThr) rxThrQ <= wrData[LEVEL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |(statusVal & maskQ);
  end

  assign maskVal = maskQ;
  assign txThr   = txThrQ;
  assign rxThr   = rxThrQ;
  assign irq     = irqQ;

  a_r2_set_bits: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrMaskSet |=> ((maskQ & $past(wrBits)) == $past(wrBits)));
  a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrMaskClr |=> ((maskQ & $past(wrBits)) == '0));
  a_r4_mask_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.wrMaskSet || strobes.wrMaskClr) |=> $stable(maskQ));
  a_r12_irq_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |=> !irq);
  a_r13_thr_indep: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrTxThr |=> $stable(rxThrQ));
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
  import spi_irq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int DEPTH      = 128,
  parameter int TX_THR_RST = 1,
  parameter int RX_THR_RST = 1,
  localparam int LEVEL_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [2:0]         addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               rdValid,
  input  logic [LEVEL_W-1:0] txLevel,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic               evRxOverrun,
  input  logic               evModeFail,
  input  logic               evTxUnderflow,
  output logic               irq
);
  ctrlStrobes_t       strobes;
  logic [NUM_SRC-1:0] statusVal;
  logic [NUM_SRC-1:0] maskVal;
  logic [LEVEL_W-1:0] txThr;
  logic [LEVEL_W-1:0] rxThr;

  spi_irq_ctrl #(.DATA_W(DATA_W), .LEVEL_W(LEVEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .statusVal(statusVal), .maskVal(maskVal), .txThr(txThr), .rxThr(rxThr),
    .strobes(strobes), .rdData(rdData), .rdValid(rdValid)
  );

  spi_irq_datapath #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .LEVEL_W(LEVEL_W),
    .TX_THR_RST(TX_THR_RST), .RX_THR_RST(RX_THR_RST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .txLevel(txLevel), .rxLevel(rxLevel),
    .evRxOverrun(evRxOverrun), .evModeFail(evModeFail), .evTxUnderflow(evTxUnderflow),
    .statusVal(statusVal), .maskVal(maskVal), .txThr(txThr), .rxThr(rxThr), .irq(irq)
  );
endmodule

// File: tb/sim_spi_irq_unit.sv
module sim_spi_irq_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int DEPTH = 128;
  localparam int LEVEL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [2:0] addr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic rdValid;
  logic [LEVEL_W-1:0] txLevel = '0;
  logic [LEVEL_W-1:0] rxLevel = '0;
  logic evRxOverrun = 1'b0;
  logic evModeFail = 1'b0;
  logic evTxUnderflow = 1'b0;
  logic irq;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] expQ[$];
  string tagQ[$];

  // Bench model, built from the requirements.
  logic [6:0] stickyM = '0;
  int txT = 1;
  int rxT = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_irq_unit #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .txLevel(txLevel), .rxLevel(rxLevel), .evRxOverrun(evRxOverrun),
    .evModeFail(evModeFail), .evTxUnderflow(evTxUnderflow), .irq(irq)
  );

  function automatic logic [DATA_W-1:0] expStatus();
    logic [6:0] s;
    s = stickyM & 7'b100_0011;
    s[2] = (int'(txLevel) < txT);
    s[3] = (int'(txLevel) == DEPTH);
    s[4] = (int'(rxLevel) >= rxT);
    s[5] = (int'(rxLevel) == DEPTH);
    return DATA_W'(s);
  endfunction

  task automatic doWrite(input logic [2:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic doRead(input logic [2:0] a, input logic [DATA_W-1:0] e, input string tag);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic checkIrq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq actual %0b expected %0b", tag, irq, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares each returned read against the scoreboard queue.
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL unexpected read data actual %0h expected none", rdData);
      end else begin
        logic [DATA_W-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (rdData !== e) begin
          errors++;
          $display("FAIL %s read actual %0h expected %0h", t, rdData, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (rdValid !== 1'b0) begin
      errors++; $display("FAIL R1 rdValid actual %0b expected 0", rdValid);
    end
    rstN = 1'b1;
    idle(1);
    checkIrq(1'b0, "R1");
    doRead(3'd3, 0, "R1 mask");
    doRead(3'd4, 1, "R1 txthr");
    doRead(3'd5, 1, "R1 rxthr");
    doRead(3'd0, expStatus(), "R1 status");

    // R2 mask set keeps other bits
    doWrite(3'd1, 32'h11);
    doRead(3'd3, 32'h11, "R2 mask after set");
    doWrite(3'd1, 32'h04);
    doRead(3'd3, 32'h15, "R2 mask accumulates");
    doRead(3'd1, 0, "R2 set port reads zero");
    doRead(3'd2, 0, "R2 clear port reads zero");

    // R4 mask address is read-only
    doWrite(3'd3, 32'h7F);
    doRead(3'd3, 32'h15, "R4 mask write ignored");

    // R3 mask clear
    doWrite(3'd2, 32'h10);
    doRead(3'd3, 32'h05, "R3 mask after clear");

    // R12 irq from transmit-low with mask bit 2
    idle(2);
    checkIrq(1'b1, "R12 irq set");
    @(negedge clk);
    txLevel = 5;
    #1 checkIrq(1'b1, "R12 irq not combinational");
    @(negedge clk);
    checkIrq(1'b0, "R12 irq one cycle later");

    // R5 transmit threshold comparison
    doWrite(3'd4, 64); txT = 64;
    txLevel = 63;
    doRead(3'd0, expStatus(), "R5 tx below threshold");
    txLevel = 64;
    doRead(3'd0, expStatus(), "R5 tx at threshold");
    // R6 transmit full
    txLevel = 128;
    doRead(3'd0, expStatus(), "R6 tx full");
    txLevel = 127;
    doRead(3'd0, expStatus(), "R6 tx one short of full");

    // R7 receive threshold
    doWrite(3'd5, 64); rxT = 64;
    rxLevel = 63;
    doRead(3'd0, expStatus(), "R7 rx below threshold");
    rxLevel = 64;
    doRead(3'd0, expStatus(), "R7 rx at threshold");
    // R8 receive full
    rxLevel = 128;
    doRead(3'd0, expStatus(), "R8 rx full");

    // R13 independent thresholds
    doRead(3'd4, 64, "R13 txthr");
    doWrite(3'd4, 3); txT = 3;
    doRead(3'd5, 64, "R13 rxthr unchanged");
    doRead(3'd4, 3, "R13 txthr updated");

    // R9 sticky events
    txLevel = 10; rxLevel = 0;
    @(negedge clk); evRxOverrun = 1'b1;
    @(negedge clk); evRxOverrun = 1'b0; stickyM[0] = 1'b1;
    idle(3);
    doRead(3'd0, expStatus(), "R9 overrun sticky");
    @(negedge clk); evModeFail = 1'b1; evTxUnderflow = 1'b1;
    @(negedge clk); evModeFail = 1'b0; evTxUnderflow = 1'b0; stickyM[1] = 1'b1; stickyM[6] = 1'b1;
    doRead(3'd0, expStatus(), "R9 all sticky");

    // R10 selective clear, level bits untouched
    txLevel = 0;
    doWrite(3'd0, 32'h3D); stickyM[0] = 1'b0;
    doRead(3'd0, expStatus(), "R10 clear overrun only");
    doWrite(3'd0, expStatus()); stickyM = '0;
    doRead(3'd0, expStatus(), "R10 write back clears all");

    // R11 event and clear in the same cycle
    @(negedge clk);
    wrEn = 1'b1; addr = 3'd0; wrData = 32'h01; evRxOverrun = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; evRxOverrun = 1'b0; stickyM[0] = 1'b1;
    doRead(3'd0, expStatus(), "R11 event wins over clear");

    // R12 irq from sticky underflow
    doWrite(3'd2, 32'h7F);
    doWrite(3'd0, 32'h7F); stickyM = '0;
    idle(2);
    checkIrq(1'b0, "R12 irq off with empty mask");
    doWrite(3'd1, 32'h40);
    idle(1);
    checkIrq(1'b0, "R12 irq off without event");
    @(negedge clk); evTxUnderflow = 1'b1;
    @(negedge clk); evTxUnderflow = 1'b0;
    checkIrq(1'b0, "R12 irq lags sticky by one");
    @(negedge clk);
    checkIrq(1'b1, "R12 irq from underflow");
    doWrite(3'd0, 32'h40);
    idle(1);
    checkIrq(1'b0, "R12 irq after acknowledge");

    idle(3);
    if (expQ.size() != 0) begin
      errors++; checks++;
      $display("FAIL reads missing actual %0d expected 0", expQ.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule